// File: doc/BRIEF.md
# Static Bus Sizing Transfer Splitter

This block sits between a requester with a 32-bit internal data path and an external data bus whose width depends on the selected region. The region can be 8, 16 or 32 bits wide. The block accepts one operand request: a byte, a word or a longword, with its address, direction and write data. With the request come the region's port-size code and its burst-enable setting. The block breaks the operand into port-width beats and places each beat on the most significant lanes of the bus. On reads it collects each beat's lanes back into a right-aligned operand.

Beats leave most significant byte first, and the address steps by the port width on every beat. The cycle controller acknowledges each beat with a termination pulse, and only then does the block move on to the next beat. After the last beat is acknowledged, the block raises a one-cycle done pulse with the read data assembled. Each beat is flagged as part of a burst only when burst is enabled and the operand needs more than one beat. Otherwise every beat is an independent single transfer. Address decoding, wait states and termination timing are handled elsewhere.

Top module: `bus_sizer`

## Requirements
- R1: After reset, `busy`, `beat_valid` and `done` are low.
- R2: `port_sel` encodes 00 = 32-bit, 01 = 8-bit, 10 = 16-bit and 11 = 32-bit (reserved). `req_size` encodes 00 = byte, 01 = word, 10 = longword and 11 = longword. Write and read operands are right-aligned: a byte uses bits [7:0] and a word uses bits [15:0].
- R3: A request produces operand-bytes / port-bytes beats when the operand is wider than the port, and one beat otherwise. `beat_last` marks the final beat. Operands are naturally aligned.
- R4: On an 8-bit port, only lane 3 (bus bits [31:24]) is enabled, and all other data bits are zero.
- R5: On a 16-bit port, only lanes 3 and 2 (bus bits [31:16]) are enabled.
- R6: When the operand is no wider than the port, byte offset o = address mod port-bytes places the operand starting at lane 3-o. The enabled bits are [31-8o] downward, most significant byte first.
- R7: Beats carry the operand most significant byte first, and `beat_addr` grows by the port width in bytes after each beat.
- R8: Without `beat_term`, the current beat's address, data and lanes hold.
- R9: With `burst_en` = 1 and more than one beat, every beat has `beat_burst` = 1.
- R10: With `burst_en` = 0, `beat_burst` is never set.
- R11: A single-beat request never sets `beat_burst`.
- R12: One cycle after `beat_term` on the last beat, `done` pulses for one cycle. In that cycle `rd_data` holds the operand collected from the enabled lanes, right-aligned and zero-extended.
- R13: `req_valid` has no effect while a transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Operand request; accepted when not busy |
| req_addr | input | ADDR_W | Operand byte address |
| req_size | input | 2 | Operand size code |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Right-aligned write operand |
| port_sel | input | 2 | Region port-size code |
| burst_en | input | 1 | Region burst enable |
| beat_term | input | 1 | Current beat terminated |
| bus_rdata | input | DATA_W | External bus read data |
| busy | output | 1 | Transfer in progress |
| beat_valid | output | 1 | A beat is presented |
| beat_addr | output | ADDR_W | Beat byte address |
| beat_write | output | 1 | Beat direction |
| beat_wdata | output | DATA_W | Lane-steered write data, zero outside enabled lanes |
| beat_lanes | output | DATA_W/8 | Byte lane enables, bit 3 = bits [31:24] |
| beat_burst | output | 1 | Beat belongs to a burst |
| beat_last | output | 1 | Final beat of the operand |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Assembled read operand |

## Verification
On every cycle, assertions check the following:
- Narrow ports never enable lanes outside their upper lanes.
- A terminated beat advances the address by exactly the port width.
- A beat that is not terminated holds its address, data and lanes.
- The burst flag stays clear when burst is disabled or when there is only one beat.
- `done` follows only a terminated last beat.

Only the bench's scenarios can show the byte order of each beat's data, the read operand gathered across beats, the placement of narrow operands by offset on a wide port, and that a request made during a busy transfer leaves it intact.

// File: rtl/sizer_pkg.sv
package sizer_pkg;

  typedef enum logic [1:0] {
    PORT_32  = 2'b00,
    PORT_8   = 2'b01,
    PORT_16  = 2'b10,
    PORT_RSV = 2'b11
  } port_sel_e;

  typedef enum logic [1:0] {
    OP_BYTE = 2'b00,
    OP_WORD = 2'b01,
    OP_LONG = 2'b10,
    OP_RSV  = 2'b11
  } op_size_e;

  // Bytes carried by one beat of the selected port
  function automatic int unsigned port_bytes(logic [1:0] sel, int unsigned lanes);
    case (sel)
      2'b01:   return 1;
      2'b10:   return 2;
      default: return lanes;
    endcase
  endfunction

  // Bytes in the requested operand
  function automatic int unsigned op_bytes(logic [1:0] sz, int unsigned lanes);
    case (sz)
      2'b00:   return 1;
      2'b01:   return 2;
      default: return lanes;
    endcase
  endfunction

  // Beats needed to move n bytes over a port of p bytes
  function automatic int unsigned beat_count(int unsigned n, int unsigned p);
    return (n > p) ? n / p : 1;
  endfunction

endpackage

// File: rtl/sizer_beat_plan.sv
module sizer_beat_plan
  import sizer_pkg::*;
#(
  parameter int LANES = 4,
  parameter int CNT_W = 3
) (
  input  logic [1:0]       port_sel,
  input  logic [1:0]       op_size,
  output logic [CNT_W-1:0] port_nbytes,
  output logic [CNT_W-1:0] op_nbytes,
  output logic [CNT_W-1:0] nbeats
);

  always_comb begin
    port_nbytes = CNT_W'(port_bytes(port_sel, LANES));
    op_nbytes   = CNT_W'(op_bytes(op_size, LANES));
    nbeats      = CNT_W'(beat_count(op_bytes(op_size, LANES),
                                    port_bytes(port_sel, LANES)));
  end

endmodule

// File: rtl/sizer_lane_steer.sv
module sizer_lane_steer #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 3
) (
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W-1:0]   rdata,
  input  logic [CNT_W-1:0]    nb,
  input  logic [CNT_W-1:0]    pb,
  input  logic [CNT_W-1:0]    off,
  input  logic [CNT_W-1:0]    idx,
  output logic [DATA_W-1:0]   beat_data,
  output logic [DATA_W/8-1:0] lanes,
  output logic [DATA_W-1:0]   rd_bytes
);

  localparam int LANES = DATA_W / 8;

  int unsigned n, p, o, k, m;
  logic [LANES-1:0]  ones;
  logic [LANES-1:0]  top_mask;
  logic [DATA_W-1:0] left_op;
  logic [DATA_W-1:0] raw;
  logic [DATA_W-1:0] bit_mask;

  always_comb begin
    n        = 32'(nb);
    p        = 32'(pb);
    o        = 32'(off);
    k        = 32'(idx);
    m        = (n < p) ? n : p;
    ones     = '1;
    top_mask = ~(ones >> m);
    lanes    = top_mask >> o;
    left_op  = wdata << (DATA_W - 8 * n);
    raw      = (left_op << (8 * p * k)) >> (8 * o);
    rd_bytes = (rdata << (8 * o)) >> (DATA_W - 8 * m);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane_mask
    assign bit_mask[8*g +: 8] = {8{lanes[g]}};
  end

  assign beat_data = raw & bit_mask;

endmodule

// File: rtl/sizer_read_gather.sv
module sizer_read_gather #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              take,
  input  logic [CNT_W-1:0]  pb,
  input  logic [DATA_W-1:0] rd_bytes,
  output logic [DATA_W-1:0] acc
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc <= '0;
    else if (clear) acc <= '0;
    else if (take)  acc <= (acc << (8 * pb)) | rd_bytes;
  end

endmodule

// File: rtl/bus_sizer.sv
module bus_sizer
  import sizer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [1:0]          req_size,
  input  logic                req_write,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [1:0]          port_sel,
  input  logic                burst_en,
  input  logic                beat_term,
  input  logic [DATA_W-1:0]   bus_rdata,
  output logic                busy,
  output logic                beat_valid,
  output logic [ADDR_W-1:0]   beat_addr,
  output logic                beat_write,
  output logic [DATA_W-1:0]   beat_wdata,
  output logic [DATA_W/8-1:0] beat_lanes,
  output logic                beat_burst,
  output logic                beat_last,
  output logic                done,
  output logic [DATA_W-1:0]   rd_data
);

  localparam int LANES = DATA_W / 8;
  localparam int CNT_W = $clog2(LANES) + 1;
  localparam int OFF_W = $clog2(LANES);

  logic              busy_q, done_q, wr_q, burst_q;
  logic [1:0]        port_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [CNT_W-1:0]  pb_q, nb_q, cnt_q, idx_q;

  logic [CNT_W-1:0]  plan_pb, plan_nb, plan_cnt;
  logic [CNT_W-1:0]  pb_m1, off;
  logic [DATA_W-1:0] rd_bytes;

  // Named internal events
  logic accept, beat_take, beat_first, last_beat, final_take;

  sizer_beat_plan #(.LANES(LANES), .CNT_W(CNT_W)) u_plan (
    .port_sel   (port_sel),
    .op_size    (req_size),
    .port_nbytes(plan_pb),
    .op_nbytes  (plan_nb),
    .nbeats     (plan_cnt)
  );

  assign accept     = req_valid && !busy_q;
  assign beat_take  = busy_q && beat_term;
  assign beat_first = (idx_q == '0);
  assign last_beat  = (idx_q == cnt_q - 1'b1);
  assign final_take = beat_take && last_beat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      wr_q    <= 1'b0;
      burst_q <= 1'b0;
      port_q  <= 2'b00;
      addr_q  <= '0;
      wdata_q <= '0;
      pb_q    <= '0;
      nb_q    <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
    end else begin
      done_q <= final_take;
      if (accept) begin
        busy_q  <= 1'b1;
        wr_q    <= req_write;
        burst_q <= burst_en;
        port_q  <= port_sel;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        pb_q    <= plan_pb;
        nb_q    <= plan_nb;
        cnt_q   <= plan_cnt;
        idx_q   <= '0;
      end else if (beat_take) begin
        if (last_beat) begin
          busy_q <= 1'b0;
        end else begin
          idx_q  <= idx_q + 1'b1;
          addr_q <= addr_q + ADDR_W'(pb_q);
        end
      end
    end
  end

  assign pb_m1 = pb_q - 1'b1;
  assign off   = CNT_W'(addr_q[OFF_W-1:0]) & pb_m1;

  sizer_lane_steer #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_steer (
    .wdata    (wdata_q),
    .rdata    (bus_rdata),
    .nb       (nb_q),
    .pb       (pb_q),
    .off      (off),
    .idx      (idx_q),
    .beat_data(beat_wdata),
    .lanes    (beat_lanes),
    .rd_bytes (rd_bytes)
  );

  sizer_read_gather #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_gather (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept),
    .take    (beat_take),
    .pb      (pb_q),
    .rd_bytes(rd_bytes),
    .acc     (rd_data)
  );

  assign busy       = busy_q;
  assign beat_valid = busy_q;
  assign beat_addr  = addr_q;
  assign beat_write = wr_q;
  assign beat_burst = burst_q && (cnt_q > 1);
  assign beat_last  = busy_q && last_beat;
  assign done       = done_q;

  // ---------------- assertions ----------------
  assert_port8_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && port_q == PORT_8 |-> beat_lanes[LANES-2:0] == '0);

  assert_port16_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && port_q == PORT_16 |-> beat_lanes[LANES-3:0] == '0);

  assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_term && !beat_last |=>
      beat_addr == $past(beat_addr) + ADDR_W'(pb_q));

  assert_beat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_term |=>
      $stable(beat_addr) && $stable(beat_wdata) && $stable(beat_lanes));

  assert_no_burst_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !burst_q |-> !beat_burst);

  assert_single_no_burst_R11: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_first && beat_last |-> !beat_burst);

  assert_done_after_last_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(beat_valid && beat_term && beat_last));

  assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !beat_valid);

endmodule

// File: tb/test_bus_sizer.sv
`timescale 1ns/1ps
module test_bus_sizer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic [1:0]  port_sel = '0;
  logic        burst_en = 1'b0;
  logic        beat_term = 1'b0;
  logic [31:0] bus_rdata = '0;
  logic        busy, beat_valid, beat_write, beat_burst, beat_last, done;
  logic [31:0] beat_addr, beat_wdata, rd_data;
  logic [3:0]  beat_lanes;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #4 clk = ~clk;

  bus_sizer i_bus_sizer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .port_sel(port_sel), .burst_en(burst_en), .beat_term(beat_term),
    .bus_rdata(bus_rdata), .busy(busy), .beat_valid(beat_valid),
    .beat_addr(beat_addr), .beat_write(beat_write), .beat_wdata(beat_wdata),
    .beat_lanes(beat_lanes), .beat_burst(beat_burst), .beat_last(beat_last),
    .done(done), .rd_data(rd_data)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 20000", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One operand transfer: every beat checked, then completion checked.
  task automatic xfer(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                      input logic [31:0] wd, input logic [1:0] ps, input logic be,
                      input int stall, input logic poke, input logic [31:0] seed);
    int nbytes, pbytes, m, o, beats;
    logic [31:0] exp_rd, exp_data, rdv;
    logic [3:0]  exp_lanes;
    string lane_tag, burst_tag;
    nbytes = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    pbytes = (ps == 2'b01) ? 1 : (ps == 2'b10) ? 2 : 4;
    m      = (nbytes < pbytes) ? nbytes : pbytes;
    o      = int'(a % pbytes);
    beats  = nbytes / m;
    lane_tag  = (ps == 2'b01) ? "R4 lanes" : (ps == 2'b10) ? "R5 lanes" : "R6 lanes";
    burst_tag = !be ? "R10 burst" : (beats == 1) ? "R11 burst" : "R9 burst";
    exp_rd = '0;

    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr;
    req_wdata = wd; port_sel = ps; burst_en = be;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < beats; k++) begin
      exp_lanes = '0;
      exp_data  = '0;
      rdv = seed ^ (32'h1357_9BDF * (k + 1));
      for (int l = 0; l < 4; l++) begin
        int j;
        j = k * m + l - o;
        if (l >= o && l < o + m && j >= 0 && j < nbytes) begin
          exp_lanes[3 - l] = 1'b1;
          exp_data[31 - 8*l -: 8] = wd[8*(nbytes - 1 - j) +: 8];
          exp_rd = (exp_rd << 8) | {24'h0, rdv[31 - 8*l -: 8]};
        end
      end
      chk("R3 beat_valid", {31'h0, beat_valid}, 32'h1);
      chk("R7 beat_addr", beat_addr, a + k * pbytes);
      chk(lane_tag, {28'h0, beat_lanes}, {28'h0, exp_lanes});
      chk("R7 beat_wdata order", beat_wdata, exp_data);
      chk(burst_tag, {31'h0, beat_burst}, {31'h0, be && beats > 1});
      chk("R3 beat_last", {31'h0, beat_last}, {31'h0, k == beats - 1});
      if (k == 0 && stall > 0) begin
        if (poke) begin
          req_valid = 1'b1; req_addr = a + 32'h100; port_sel = 2'b00;
          req_size = 2'b00; burst_en = 1'b1;
        end
        repeat (stall) @(negedge clk);
        req_valid = 1'b0;
        chk("R8 hold addr", beat_addr, a);
        chk("R8 hold data", beat_wdata, exp_data);
        if (poke) begin
          chk("R13 ignored addr", beat_addr, a);
          chk("R13 ignored lanes", {28'h0, beat_lanes}, {28'h0, exp_lanes});
        end
      end
      beat_term = 1'b1;
      bus_rdata = rdv;
      @(negedge clk);
      beat_term = 1'b0;
      bus_rdata = 32'hDEAD_BEEF;
    end
    chk("R12 done pulse", {31'h0, done}, 32'h1);
    chk("R12 busy cleared", {31'h0, busy}, 32'h0);
    if (!wr) chk("R12 rd_data", rd_data, exp_rd);
    @(negedge clk);
    chk("R12 done one cycle", {31'h0, done}, 32'h0);
  endtask

  task automatic t_reset();
    chk("R1 busy", {31'h0, busy}, 32'h0);
    chk("R1 beat_valid", {31'h0, beat_valid}, 32'h0);
    chk("R1 done", {31'h0, done}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    // long write over 8-bit port as a burst
    xfer(32'h0000_1000, 2'b10, 1'b1, 32'hA1B2_C3D4, 2'b01, 1'b1, 0, 1'b0, 32'h0);
    // long read over 16-bit port, bursts disabled
    xfer(32'h0000_2004, 2'b10, 1'b0, 32'h0, 2'b10, 1'b0, 0, 1'b0, 32'h5A5A_1234);
    // byte write at offset 2 of a 32-bit port
    xfer(32'h0000_3002, 2'b00, 1'b1, 32'h0000_00E7, 2'b00, 1'b1, 0, 1'b0, 32'h0);
    // word read at offset 2 of a 32-bit port
    xfer(32'h0000_3006, 2'b01, 1'b0, 32'h0, 2'b00, 1'b1, 0, 1'b0, 32'h8642_FDB9);
    // reserved port code behaves as 32-bit (R2)
    xfer(32'h0000_4008, 2'b10, 1'b0, 32'h0, 2'b11, 1'b1, 0, 1'b0, 32'h0F1E_2D3C);
    // size code 11 as longword on 16-bit port, stalled and poked (R2, R8, R13)
    xfer(32'h0000_5010, 2'b11, 1'b1, 32'h1122_3344, 2'b10, 1'b1, 3, 1'b1, 32'h0);
    // word read over 8-bit port as a burst
    xfer(32'h0000_6002, 2'b01, 1'b0, 32'h0, 2'b01, 1'b1, 0, 1'b0, 32'hC0DE_F00D);
    // byte on 8-bit port: single beat, no burst
    xfer(32'h0000_7003, 2'b00, 1'b0, 32'h0, 2'b01, 1'b1, 0, 1'b0, 32'h7E00_0000);
    // word write at offset 1 of a 16-bit-aligned... use aligned word on 16-bit port
    xfer(32'h0000_8002, 2'b01, 1'b1, 32'h0000_9ABC, 2'b10, 1'b0, 2, 1'b0, 32'h0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule